// File: doc/BRIEF.md
# Register Address Pointer Unit

This block keeps the register address pointer of a GPIO expander that has 22 registers, arranged as 11 pairs with one port-A and one port-B member each. The serial front end loads the pointer with an 8-bit address taken from the transfer, then pulses an advance strobe after every completed data byte. The block moves the pointer according to two configuration levels. The map-select level chooses between an interleaved map, where the A and B members of a pair sit side by side, and a split map, where the A bank and the B bank are separate. The byte-mode level chooses between auto-increment and repeated access.

The block drives the raw pointer and a physical register index into the register file. The index is `2*pair + side` (side 0 = A, 1 = B). In the interleaved map this index equals the address. An address that has no register under the current map raises a flag, and while the flag is high the index reads "none".

Top module: `gpx_addr_pointer`

## Requirements
- R1: After reset the pointer is 00h, the index is 0, the invalid flag is low, and sequential (incrementing) behaviour is selected by `byte_mode_i = 0`.
- R2: A load strobe puts the load address into the pointer at the next clock edge, and it wins over an advance strobe in the same cycle.
- R3: With `map_split_i = 0` (interleaved map), pointers 00h–15h are valid and the index equals the pointer: even address is side A, odd address is side B of pair `addr>>1`.
- R4: With `map_split_i = 1` (split map), pointer `p` in 00h–0Ah gives index `2*p` (side A), and pointer `p` in 10h–1Ah gives index `2*(p-10h)+1` (side B).
- R5: A pointer that is unmapped under the current map drives the invalid flag to 1 and the index to all ones (31).
- R6: Sequential mode, interleaved map: an advance adds one, and 15h wraps to 00h.
- R7: Sequential mode, split map: an advance adds one, 0Ah jumps to 10h, and 1Ah wraps to 00h.
- R8: Byte mode, split map: an advance leaves the pointer unchanged.
- R9: Byte mode, interleaved map: an advance flips address bit 0, so the pointer toggles between the two members of its pair, starting from either member.
- R10: An advance while the invalid flag is high has no effect on the pointer.
- R11: With neither strobe the pointer holds, and its index and flag follow the current map level at once (no clock needed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe from the serial front end |
| load_addr_i | input | 8 | Address to load |
| adv_i | input | 1 | Advance strobe, one per completed byte |
| map_split_i | input | 1 | 1 = split A/B banks, 0 = interleaved pairs |
| byte_mode_i | input | 1 | 1 = byte mode, 0 = sequential mode |
| ptr_o | output | 8 | Current pointer |
| reg_idx_o | output | 5 | Physical register index, all ones when invalid |
| ptr_bad_o | output | 1 | Pointer is unmapped under the current map |

## Verification
Directed cases start from each wrap point: 15h in the interleaved map, and 0Ah and 1Ah in the split map. These tell a real wrap apart from a plain increment or a jump to the wrong bank. Byte-mode toggling starts once from the even member and once from the odd member of a pair. This separates a bit-0 flip from an increment or a hold. Other cases load an unmapped address and then advance, flip the map level with the pointer held, and raise load and advance together. These isolate the flag, the combinational reinterpretation of the pointer and the load priority. Random loads, about half of them to mapped addresses, are mixed with advances and occasional mode changes, and every cycle is compared with a bench model.

// File: rtl/gpx_ptr_pkg.sv
package gpx_ptr_pkg;

  // Side of a pair; the physical index is 2*pair + side.
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

  // Physical index for a (pair, side) coordinate.
  function automatic int unsigned phys_index(int unsigned pair, side_e side);
    return 2 * pair + ((side == SIDE_B) ? 1 : 0);
  endfunction

  // Address of a pair member in the interleaved map.
  function automatic int unsigned il_addr(int unsigned pair, side_e side);
    return phys_index(pair, side);
  endfunction

  // Address of a pair member in the split map.
  function automatic int unsigned sp_addr(int unsigned pair, side_e side,
                                          int unsigned b_base);
    return (side == SIDE_B) ? (b_base + pair) : pair;
  endfunction

endpackage

// File: rtl/gpx_ptr_decode.sv
module gpx_ptr_decode #(
  parameter int unsigned N_PAIRS = 11,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned B_BASE  = 16,
  localparam int unsigned IDX_W  = $clog2(2 * N_PAIRS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              split_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  import gpx_ptr_pkg::*;

  logic [N_PAIRS-1:0] hit_a;
  logic [N_PAIRS-1:0] hit_b;

  // One comparator per pair member, address chosen by the map variant.
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] IL_A = ADDR_W'(il_addr(p, SIDE_A));
    localparam logic [ADDR_W-1:0] IL_B = ADDR_W'(il_addr(p, SIDE_B));
    localparam logic [ADDR_W-1:0] SP_A = ADDR_W'(sp_addr(p, SIDE_A, B_BASE));
    localparam logic [ADDR_W-1:0] SP_B = ADDR_W'(sp_addr(p, SIDE_B, B_BASE));
    assign hit_a[p] = (addr_i == (split_i ? SP_A : IL_A));
    assign hit_b[p] = (addr_i == (split_i ? SP_B : IL_B));
  end

  // OR-encode the one-hot hits into the physical index.
  always_comb begin
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < N_PAIRS; p++) begin
      if (hit_a[p]) acc = acc | IDX_W'(phys_index(p, SIDE_A));
      if (hit_b[p]) acc = acc | IDX_W'(phys_index(p, SIDE_B));
    end
    hit_o = |{hit_a, hit_b};
    idx_o = hit_o ? acc : '1;
  end

endmodule

// File: rtl/gpx_ptr_step.sv
module gpx_ptr_step #(
  parameter int unsigned N_PAIRS = 11,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned B_BASE  = 16
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              split_i,
  input  logic              byte_mode_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] IL_LAST = ADDR_W'(2 * N_PAIRS - 1);
  localparam logic [ADDR_W-1:0] SP_LAST_A = ADDR_W'(N_PAIRS - 1);
  localparam logic [ADDR_W-1:0] SP_FIRST_B = ADDR_W'(B_BASE);
  localparam logic [ADDR_W-1:0] SP_LAST_B = ADDR_W'(B_BASE + N_PAIRS - 1);

  typedef enum logic [1:0] {
    MV_INC_IL, MV_INC_SP, MV_TOGGLE, MV_HOLD
  } move_e;

  move_e move;

  always_comb begin
    unique case ({byte_mode_i, split_i})
      2'b00:   move = MV_INC_IL;
      2'b01:   move = MV_INC_SP;
      2'b10:   move = MV_TOGGLE;
      default: move = MV_HOLD;
    endcase
  end

  always_comb begin
    wrap_o = 1'b0;
    nxt_o  = ptr_i;
    unique case (move)
      MV_INC_IL: begin
        if (ptr_i == IL_LAST) begin
          nxt_o  = '0;
          wrap_o = 1'b1;
        end else begin
          nxt_o = ptr_i + 1'b1;
        end
      end
      MV_INC_SP: begin
        if (ptr_i == SP_LAST_B) begin
          nxt_o  = '0;
          wrap_o = 1'b1;
        end else if (ptr_i == SP_LAST_A) begin
          nxt_o = SP_FIRST_B;
        end else begin
          nxt_o = ptr_i + 1'b1;
        end
      end
      MV_TOGGLE: nxt_o = {ptr_i[ADDR_W-1:1], ~ptr_i[0]};
      default:   nxt_o = ptr_i;
    endcase
  end

endmodule

// File: rtl/gpx_ptr_reg.sv
module gpx_ptr_reg #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_addr_i;
    else if (step_i) ptr_o <= nxt_i;
  end
endmodule

// File: rtl/gpx_addr_pointer.sv
module gpx_addr_pointer #(
  parameter int unsigned N_PAIRS = 11,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned B_BASE  = 16,
  localparam int unsigned IDX_W  = $clog2(2 * N_PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  input  logic              map_split_i,
  input  logic              byte_mode_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              ptr_bad_o
);
  logic              ptr_hit;
  logic [ADDR_W-1:0] step_nxt;
  logic              wrap_evt;
  logic              load_evt;
  logic              adv_evt;

  assign load_evt = load_i;
  assign adv_evt  = adv_i & ~load_i & ptr_hit;

  gpx_ptr_decode #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W), .B_BASE(B_BASE)) u_dec (
    .addr_i (ptr_o),
    .split_i(map_split_i),
    .hit_o  (ptr_hit),
    .idx_o  (reg_idx_o)
  );

  gpx_ptr_step #(.N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W), .B_BASE(B_BASE)) u_step (
    .ptr_i      (ptr_o),
    .split_i    (map_split_i),
    .byte_mode_i(byte_mode_i),
    .nxt_o      (step_nxt),
    .wrap_o     (wrap_evt)
  );

  gpx_ptr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .load_addr_i(load_addr_i),
    .step_i     (adv_evt),
    .nxt_i      (step_nxt),
    .ptr_o      (ptr_o)
  );

  assign ptr_bad_o = ~ptr_hit;

endmodule

// File: rtl/gpx_ptr_chk.sv
module gpx_ptr_chk #(
  parameter int unsigned N_PAIRS = 11,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned B_BASE  = 16,
  localparam int unsigned IDX_W  = $clog2(2 * N_PAIRS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              adv_i,
  input logic              map_split_i,
  input logic              byte_mode_i,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              ptr_bad_o,
  input logic              adv_evt,
  input logic              wrap_evt
);
  localparam logic [ADDR_W-1:0] IL_LAST   = ADDR_W'(2 * N_PAIRS - 1);
  localparam logic [ADDR_W-1:0] SP_LAST_A = ADDR_W'(N_PAIRS - 1);
  localparam logic [ADDR_W-1:0] SP_LAST_B = ADDR_W'(B_BASE + N_PAIRS - 1);

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ptr_o == $past(load_addr_i));

  // R5
  bad_idx_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_bad_o |-> reg_idx_o == '1);

  // R3
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_bad_o |-> int'(reg_idx_o) < 2 * N_PAIRS);

  // R6
  il_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !byte_mode_i && !map_split_i && ptr_o == IL_LAST) |=> ptr_o == '0);

  // R7
  sp_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !byte_mode_i && map_split_i && ptr_o == SP_LAST_A)
      |=> ptr_o == ADDR_W'(B_BASE));

  // R7
  sp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !byte_mode_i && map_split_i && ptr_o == SP_LAST_B) |=> ptr_o == '0);

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && byte_mode_i && map_split_i) |=> $stable(ptr_o));

  // R9
  byte_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && byte_mode_i && !map_split_i) |=> ptr_o == ($past(ptr_o) ^ ADDR_W'(1)));

  // R10
  bad_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && ptr_bad_o) |=> $stable(ptr_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(ptr_o));

  // R6
  wrap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && adv_evt) |=> ptr_o == '0);

endmodule

bind gpx_addr_pointer gpx_ptr_chk #(
  .N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W), .B_BASE(B_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
  .adv_i(adv_i), .map_split_i(map_split_i), .byte_mode_i(byte_mode_i),
  .ptr_o(ptr_o), .reg_idx_o(reg_idx_o), .ptr_bad_o(ptr_bad_o),
  .adv_evt(adv_evt), .wrap_evt(wrap_evt)
);

// File: tb/sim_gpx_addr_pointer.sv
`timescale 1ns/1ps
module sim_gpx_addr_pointer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_addr_i = '0;
  logic       adv_i = 1'b0;
  logic       map_split_i = 1'b0;
  logic       byte_mode_i = 1'b0;
  logic [7:0] ptr_o;
  logic [4:0] reg_idx_o;
  logic       ptr_bad_o;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;
  string prev_tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpx_addr_pointer u0 (.*);

  // Index from the maps: interleaved index = address; split A at 0..10, B at 16..26.
  function automatic int want_idx(int a, bit split);
    if (!split) return (a < 22) ? a : -1;
    if (a < 11) return a * 2;
    if (a >= 16 && a < 27) return (a - 16) * 2 + 1;
    return -1;
  endfunction

  function automatic int want_next(int a, bit split, bit bytem);
    if (want_idx(a, split) < 0) return a;
    if (bytem) return split ? a : (a ^ 1);
    if (!split) return (a == 21) ? 0 : a + 1;
    if (a == 10) return 16;
    if (a == 26) return 0;
    return a + 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic verify();
    int e;
    string t;
    e = want_idx(model, map_split_i);
    t = (prev_tag == "R11") ? "R11" : ((e < 0) ? "R5" : (map_split_i ? "R4" : "R3"));
    check(prev_tag, int'(ptr_o), model, "ptr");
    check(t, int'(reg_idx_o), (e < 0) ? 31 : e, "idx");
    check(t, int'(ptr_bad_o), (e < 0) ? 1 : 0, "bad");
  endtask

  task automatic apply(bit ld, int ad, bit av, bit sp, bit bm, string tg);
    @(negedge clk);
    verify();
    load_i = ld; load_addr_i = 8'(ad); adv_i = av;
    map_split_i = sp; byte_mode_i = bm;
    prev_tag = tg;
    if (ld) model = ad;
    else if (av) model = want_next(model, sp, bm);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(ptr_o), 0, "ptr");
    check("R1", int'(reg_idx_o), 0, "idx");
    check("R1", int'(ptr_bad_o), 0, "bad");
    rst_n = 1'b1;
    model = 0;
    // R9 toggle from both members
    apply(1, 8'h12, 0, 0, 1, "R2");
    apply(0, 0, 1, 0, 1, "R9");
    apply(0, 0, 1, 0, 1, "R9");
    apply(1, 8'h13, 0, 0, 1, "R2");
    apply(0, 0, 1, 0, 1, "R9");
    // R6 wrap
    apply(1, 8'h15, 0, 0, 0, "R2");
    apply(0, 0, 1, 0, 0, "R6");
    apply(0, 0, 1, 0, 0, "R6");
    // R7 jump and wrap
    apply(1, 8'h0A, 0, 1, 0, "R2");
    apply(0, 0, 1, 1, 0, "R7");
    apply(1, 8'h1A, 0, 1, 0, "R2");
    apply(0, 0, 1, 1, 0, "R7");
    // R8 hold
    apply(1, 8'h05, 0, 1, 1, "R2");
    apply(0, 0, 1, 1, 1, "R8");
    apply(0, 0, 1, 1, 1, "R8");
    // R5 / R10 unmapped, R11 map flip
    apply(1, 8'h0C, 0, 1, 0, "R2");
    apply(0, 0, 1, 1, 0, "R10");
    apply(0, 0, 0, 0, 0, "R11");
    apply(0, 0, 0, 1, 0, "R11");
    apply(1, 8'h16, 0, 0, 0, "R2");
    apply(0, 0, 1, 0, 1, "R10");
    // R2 load beats advance
    apply(1, 8'h03, 1, 0, 0, "R2");
    apply(1, 8'h11, 1, 1, 1, "R2");
    apply(0, 0, 0, 1, 1, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit ld, av, sp, bm;
      int ad;
      string tg;
      ld = ($urandom % 5) == 0;
      av = ($urandom % 3) != 0;
      sp = (($urandom % 12) == 0) ? ~map_split_i : map_split_i;
      bm = (($urandom % 10) == 0) ? ~byte_mode_i : byte_mode_i;
      case ($urandom % 4)
        0:       ad = $urandom % 22;
        1:       ad = 16 + ($urandom % 11);
        default: ad = $urandom % 256;
      endcase
      if (ld) tg = "R2";
      else if (!av) tg = "R11";
      else if (want_idx(model, sp) < 0) tg = "R10";
      else if (bm) tg = sp ? "R8" : "R9";
      else tg = sp ? "R7" : "R6";
      apply(ld, ad, av, sp, bm, tg);
    end
    @(negedge clk);
    verify();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule